// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the byte-wide register file behind a general-purpose I/O expander with 8, 16, 32 or 64 pins. Every pin owns one bit in each of five register groups: direction, level, interrupt enable, interrupt status and a spare scratch group. A host reaches the groups over a simple synchronous register bus with an 8-bit address and 8-bit data. On the pin side the block drives output values and output enables and samples the pad inputs.

The pins are split into banks of eight. A group's first byte sits at the group number shifted left by the bank shift (log2 of the pin count, minus three). Each group therefore occupies one byte per bank, and the same address rule serves every pin count. Interrupt trigger evaluation lives outside this block. It reads the enable bits and feeds per-pin event pulses into the status bits.

Top module: `gpx_regfile`

## Requirements
- R1: While reset is high and on the cycle after it, every direction, output latch, interrupt-enable, interrupt-status and spare bit is 0. So pad_oe, pad_out, int_en and int_stat are all zero and every pin is an input.
- R2: With S = log2(PINS) - 3, the byte of group g for bank b is at address (g << S) + b. The groups are g = 0 direction, 1 level, 2 interrupt enable, 3 interrupt status and 4 spare. Pin n is bit n mod 8 of bank n / 8. Banks never alias one another.
- R3: A direction bit of 1 makes the pin an output (pad_oe high) and 0 makes it an input. The direction byte reads back exactly the value last written, and pad_oe shows it on the cycle after the write.
- R4: Writing a level byte loads the output latches, which appear on pad_out on the next cycle. A level bit of an output pin reads back the latched value, whatever the pad shows.
- R5: A level bit of an input pin reads a copy of the pad taken through two flops. A pad change set up before clock edge k is returned by a read sampled at edge k+2, and not by reads sampled at edges k or k+1.
- R6: The interrupt-enable bytes are read/write and drive int_en.
- R7: A status bit is set by a one-cycle pulse on evt_set and stays set. Writing 1 to it clears it and writing 0 leaves it alone. A set and a clear in the same cycle leave it set.
- R8: The spare group is plain read/write storage with no effect on the pins.
- R9: A read of any address whose group number is 5 or more returns 0x00. A write to such an address changes no register.
- R10: bus_rdata is registered. It carries the value of the address presented with bus_ren on the following cycle, and holds its value while bus_ren is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after bus_ren |
| pad_in | input | PINS | Pad input levels (asynchronous) |
| pad_out | output | PINS | Output latch values |
| pad_oe | output | PINS | Output enables, 1 = driven |
| evt_set | input | PINS | Per-pin event pulses that set status bits |
| int_en | output | PINS | Interrupt-enable bits |
| int_stat | output | PINS | Interrupt-status bits |

## Verification
A wrong bank or group decode shows up one cycle after the faulty write. The pad_oe, pad_out or int_en bits of some other bank change, or the written byte reads back from the wrong address. A fault in the level mux or the synchronizer appears on bus_rdata at the first read after a pad change. The two-flop delay is pinned exactly by comparing three back-to-back reads. Faults in status clear priority, or in decoding unmapped writes, show up on int_stat or the spare readback in the cycle right after the offending access.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [2:0] {
        GRP_DIR = 3'd0,
        GRP_LVL = 3'd1,
        GRP_IEN = 3'd2,
        GRP_IST = 3'd3,
        GRP_SPR = 3'd4
    } grp_e;

    localparam int NUM_GRP = 5;

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] lat;
        logic [7:0] ien;
        logic [7:0] ist;
        logic [7:0] spr;
    } bank_regs_t;

    function automatic int bank_shift(input int pins);
        return $clog2(pins) - 3;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int PINS = 16,
    localparam int SHIFT  = bank_shift(PINS),
    localparam int BIDX_W = (SHIFT == 0) ? 1 : SHIFT
) (
    input  logic [7:0]        addr_i,
    output logic              hit_o,
    output grp_e              grp_o,
    output logic [BIDX_W-1:0] bank_o
);
    logic [7:0] grp_raw;

    assign grp_raw = addr_i >> SHIFT;
    assign hit_o   = (grp_raw < 8'(NUM_GRP));
    assign grp_o   = grp_e'(grp_raw[2:0]);

    generate
        if (SHIFT == 0) begin : g_one_bank
            assign bank_o = '0;
        end else begin : g_multi_bank
            assign bank_o = addr_i[BIDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_dir,
    input  logic       we_lat,
    input  logic       we_ien,
    input  logic       we_ist,
    input  logic       we_spr,
    input  logic [7:0] wdata,
    input  logic [7:0] pad_sync,
    input  logic [7:0] evt,
    output bank_regs_t regs_o,
    output logic [7:0] lvl_o
);
    bank_regs_t r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            if (we_dir) r_q.dir <= wdata;
            if (we_lat) r_q.lat <= wdata;
            if (we_ien) r_q.ien <= wdata;
            if (we_spr) r_q.spr <= wdata;
            r_q.ist <= (r_q.ist & ~(we_ist ? wdata : 8'h00)) | evt;
        end
    end

    assign regs_o = r_q;
    assign lvl_o  = (r_q.dir & r_q.lat) | (~r_q.dir & pad_sync);

    // Any pulsed event is visible as set status on the next cycle, clear or not
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt != 8'h00) |=> ((regs_o.ist & $past(evt)) == $past(evt))); // R7
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int PINS = 16,
    localparam int SHIFT  = bank_shift(PINS),
    localparam int NBANK  = 1 << SHIFT,
    localparam int BIDX_W = (SHIFT == 0) ? 1 : SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wen,
    input  logic [7:0]      bus_wdata,
    input  logic            bus_ren,
    output logic [7:0]      bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    input  logic [PINS-1:0] evt_set,
    output logic [PINS-1:0] int_en,
    output logic [PINS-1:0] int_stat
);
    logic              dec_hit;
    grp_e              dec_grp;
    logic [BIDX_W-1:0] dec_bank;
    logic [PINS-1:0]   pad_sync;
    bank_regs_t        regs [NBANK];
    logic [7:0]        lvl  [NBANK];
    logic [7:0]        rd_val;
    logic [7:0]        rdata_q;

    gpx_decode #(.PINS(PINS)) u_decode (
        .addr_i (bus_addr),
        .hit_o  (dec_hit),
        .grp_o  (dec_grp),
        .bank_o (dec_bank)
    );

    gpx_sync #(.WIDTH(PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic sel;
            assign sel = bus_wen && dec_hit && (dec_bank == BIDX_W'(b));

            gpx_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .we_dir   (sel && (dec_grp == GRP_DIR)),
                .we_lat   (sel && (dec_grp == GRP_LVL)),
                .we_ien   (sel && (dec_grp == GRP_IEN)),
                .we_ist   (sel && (dec_grp == GRP_IST)),
                .we_spr   (sel && (dec_grp == GRP_SPR)),
                .wdata    (bus_wdata),
                .pad_sync (pad_sync[8*b +: 8]),
                .evt      (evt_set[8*b +: 8]),
                .regs_o   (regs[b]),
                .lvl_o    (lvl[b])
            );

            assign pad_oe[8*b +: 8]   = regs[b].dir;
            assign pad_out[8*b +: 8]  = regs[b].lat;
            assign int_en[8*b +: 8]   = regs[b].ien;
            assign int_stat[8*b +: 8] = regs[b].ist;

            // A direction write reaches this bank's output enables one cycle later
            AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
                (bus_wen && dec_hit && dec_grp == GRP_DIR && dec_bank == BIDX_W'(b))
                |=> (pad_oe[8*b +: 8] == $past(bus_wdata))); // R3
        end
    endgenerate

    always_comb begin
        rd_val = 8'h00;
        if (dec_hit) begin
            case (dec_grp)
                GRP_DIR: rd_val = regs[dec_bank].dir;
                GRP_LVL: rd_val = lvl[dec_bank];
                GRP_IEN: rd_val = regs[dec_bank].ien;
                GRP_IST: rd_val = regs[dec_bank].ist;
                GRP_SPR: rd_val = regs[dec_bank].spr;
                default: rd_val = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (bus_ren) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0 && int_en == '0 && int_stat == '0)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && !dec_hit) |=> (bus_rdata == 8'h00)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_ren && !$past(rst)) |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/test_gpx_regfile.sv
module test_gpx_regfile;
    localparam int PINS = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      bus_addr = '0;
    logic            bus_wen = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic            bus_ren = 1'b0;
    logic [7:0]      bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out;
    logic [PINS-1:0] pad_oe;
    logic [PINS-1:0] evt_set = '0;
    logic [PINS-1:0] int_en;
    logic [PINS-1:0] int_stat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    gpx_regfile #(.PINS(PINS)) i_gpx_regfile (
        .clk, .rst, .bus_addr, .bus_wen, .bus_wdata, .bus_ren, .bus_rdata,
        .pad_in, .pad_out, .pad_oe, .evt_set, .int_en, .int_stat
    );

    // Address map for 16 pins (S = 1): dir 0/1, lvl 2/3, ien 4/5, ist 6/7, spr 8/9
    // Each entry: write address, write data, read address, expected read
    localparam logic [31:0] VEC [10] = '{
        {8'h00, 8'hA5, 8'h00, 8'hA5},   // R3 dir bank0
        {8'h01, 8'h3C, 8'h01, 8'h3C},   // R3 R2 dir bank1
        {8'h04, 8'h0F, 8'h04, 8'h0F},   // R6 ien bank0
        {8'h05, 8'hF0, 8'h05, 8'hF0},   // R6 ien bank1
        {8'h08, 8'h5A, 8'h08, 8'h5A},   // R8 spare bank0
        {8'h09, 8'hC3, 8'h09, 8'hC3},   // R8 spare bank1
        {8'h0A, 8'hFF, 8'h0A, 8'h00},   // R9 unmapped reads zero
        {8'hFF, 8'h11, 8'h08, 8'h5A},   // R9 unmapped write ignored
        {8'h08, 8'h66, 8'h01, 8'h3C},   // R2 no aliasing between banks
        {8'h00, 8'h00, 8'h00, 8'h00}    // R3 dir cleared
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_ren = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        chk("R1 oe", pad_oe, 16'h0000);
        chk("R1 out", pad_out, 16'h0000);
        chk("R1 ien", int_en, 16'h0000);
        chk("R1 ist", int_stat, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        rd(8'h00, r); chk("R1 dir read", {8'h00, r}, 16'h0000);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16]);
            rd(VEC[i][15:8], r);
            chk($sformatf("R2/R3/R6/R8/R9 vector %0d", i), {8'h00, r}, {8'h00, VEC[i][7:0]});
        end
        chk("R3 pad_oe", pad_oe, 16'h3C00);
        chk("R6 int_en", int_en, 16'hF00F);

        // R4 output latches
        wr(8'h00, 8'hFF); wr(8'h01, 8'h00);
        wr(8'h02, 8'h96); wr(8'h03, 8'h81);
        chk("R4 pad_out", pad_out, 16'h8196);
        chk("R3 pad_oe outputs", pad_oe, 16'h00FF);
        rd(8'h02, r); chk("R4 output level readback", {8'h00, r}, 16'h0096);

        // R5 synchronized input levels
        pad_in = 16'hAB00;
        repeat (3) @(negedge clk);
        rd(8'h03, r); chk("R5 input level", {8'h00, r}, 16'h00AB);
        pad_in = 16'h5400;
        rd(8'h03, r); chk("R5 sync edge k", {8'h00, r}, 16'h00AB);
        rd(8'h03, r); chk("R5 sync edge k+1", {8'h00, r}, 16'h00AB);
        rd(8'h03, r); chk("R5 sync edge k+2", {8'h00, r}, 16'h0054);

        // R4 R5 mixed bank
        wr(8'h00, 8'h0F);
        pad_in = 16'h54F0;
        repeat (3) @(negedge clk);
        rd(8'h02, r); chk("R4/R5 mixed level", {8'h00, r}, 16'h00F6);

        // R7 status
        evt_set = 16'h0102;
        @(negedge clk);
        evt_set = '0;
        chk("R7 set", int_stat, 16'h0102);
        rd(8'h06, r); chk("R7 read bank0", {8'h00, r}, 16'h0002);
        rd(8'h07, r); chk("R7 read bank1", {8'h00, r}, 16'h0001);
        wr(8'h06, 8'h00); chk("R7 write zero keeps", int_stat, 16'h0102);
        wr(8'h06, 8'h02); chk("R7 w1c", int_stat, 16'h0100);
        evt_set = 16'h0100;
        wr(8'h07, 8'h01);
        evt_set = '0;
        chk("R7 set wins", int_stat, 16'h0100);
        wr(8'h07, 8'h01); chk("R7 clear", int_stat, 16'h0000);

        // R10 registered and held
        rd(8'h08, r); chk("R10 read", {8'h00, r}, 16'h0066);
        wr(8'h08, 8'h77);
        @(negedge clk);
        chk("R10 hold", {8'h00, bus_rdata}, 16'h0066);
        rd(8'h08, r); chk("R10 new value", {8'h00, r}, 16'h0077);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 oe after reset", pad_oe, 16'h0000);
        chk("R1 out after reset", pad_out, 16'h0000);
        chk("R1 ien after reset", int_en, 16'h0000);
        rd(8'h08, r); chk("R1 spare after reset", {8'h00, r}, 16'h0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule